// File: doc/BRIEF.md
# Shadowed Position Compare Unit

This block watches a 32-bit position count and compares it with an active compare value. When the count moves onto the compare value, a sticky match flag is raised and a sync pulse is launched on an output pin. The pulse is stretched to a programmable length in multiples of four clocks, and its active level is selectable, so that an external device can be triggered reliably.

The compare value can be written in two ways. With shadowing off, a write lands straight in the active register. With shadowing on, a write lands in a holding register and is copied into the active register only on a chosen event: a compare match, or the count arriving at zero. Each such copy raises a sticky ready flag. Both flags stay set until a one-cycle clear input is pulsed. The position counter is supplied from outside the block.

Top module: `pos_compare_unit`

## Requirements
- R1: With shadow_en low, a write (wr_en high) places wr_data in the active compare register, and it is used for comparison from the next cycle.
- R2: With shadow_en high, a write changes only the holding register; the active compare value stays unchanged until a load event.
- R3: With shadow_en high and load_sel low, the holding value is copied to the active register on a compare match; the comparison in that cycle uses the old active value and the new value applies from the next cycle.
- R4: With shadow_en high and load_sel high, the holding value is copied to the active register when the count changes from a nonzero value to zero; matches then cause no copy.
- R5: ready_flag goes high on the clock edge that performs a holding-to-active copy, and only then.
- R6: match_flag goes high on the clock edge after the count changes to equal the active value; a count that stays equal does not produce further matches.
- R7: Both flags stay high until their clear input is pulsed; when a set and a clear occur in the same cycle, the flag stays set.
- R8: A match starts a pulse on sync_out at the same edge that sets match_flag, lasting (pulse_width + 1) x 4 clock cycles.
- R9: A match during an active pulse neither restarts nor extends it.
- R10: With sync_low high, sync_out idles high and pulses low; with sync_low low, it idles low and pulses high.
- R11: After reset both flags are low, both compare registers hold zero and sync_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Compare write strobe |
| wr_data | input | 32 | Compare value to write |
| shadow_en | input | 1 | 1: writes go to holding register |
| load_sel | input | 1 | 0: copy on match, 1: copy on count zero |
| pulse_width | input | 8 | Pulse length code, (code+1)*4 cycles |
| sync_low | input | 1 | 1: sync_out is active low |
| count | input | 32 | Position count value |
| match_clr | input | 1 | Clear pulse for match_flag |
| ready_clr | input | 1 | Clear pulse for ready_flag |
| match_flag | output | 1 | Sticky compare-match flag |
| ready_flag | output | 1 | Sticky compare-ready flag |
| sync_out | output | 1 | Stretched sync pulse |

## Verification
A wrong active compare value shows at the ports one cycle after the count reaches the intended value, as a missing or misplaced match_flag, so the bench leads the count across both the old and new compare values after each write and each load. A wrong previous-count register shows as a repeated or missing match when the count holds still, and a broken stretch counter shows as a pulse whose length in cycles differs from (code+1)*4, measured cycle by cycle, including a retrigger in mid-pulse.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned POS_W = 32;
  localparam int unsigned PW_W  = 8;

  typedef enum logic {
    LOAD_AT_MATCH = 1'b0,
    LOAD_AT_ZERO  = 1'b1
  } load_sel_e;
endpackage

// File: rtl/pcu_cmp_regs.sv
module pcu_cmp_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         shadow_en,
  input  logic         load_now,
  output logic [W-1:0] active_o,
  output logic         xfer_o
);
  logic [W-1:0] hold_q;
  logic [W-1:0] active_q;
  logic         xfer;

  assign xfer = shadow_en & load_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      active_q <= '0;
    end else begin
      if (wr_en && shadow_en) hold_q <= wr_data;
      if (wr_en && !shadow_en) active_q <= wr_data;
      else if (xfer) active_q <= hold_q;
    end
  end

  assign active_o = active_q;
  assign xfer_o   = xfer;

  // R1
  direct_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !shadow_en) |=> (active_q == $past(wr_data)));

  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (shadow_en && !load_now) |=> $stable(active_q));
endmodule

// File: rtl/pcu_event_det.sv
module pcu_event_det #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] count,
  input  logic [W-1:0] active,
  output logic         match_evt,
  output logic         zero_evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= count;
  end

  assign match_evt = (count == active) && (count != prev_q);
  assign zero_evt  = (count == '0) && (prev_q != '0);
endmodule

// File: rtl/pcu_pulse_gen.sv
module pcu_pulse_gen #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig_i,
  input  logic [PW-1:0] width_i,
  input  logic          low_i,
  output logic          sync_o
);
  localparam int unsigned CW = PW + 2;

  logic [CW-1:0] cnt_q;
  logic          pulse_q;
  logic          pulse_d;
  logic          sync_q;

  always_comb begin
    pulse_d = pulse_q;
    if (!pulse_q && trig_i)           pulse_d = 1'b1;
    else if (pulse_q && cnt_q == '0)  pulse_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      sync_q  <= pulse_d ^ low_i;
      if (!pulse_q && trig_i)           cnt_q <= {width_i, 2'b11};
      else if (pulse_q && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sync_o = sync_q;

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> $past(trig_i));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pos_compare_unit.sv
module pos_compare_unit
  import pcu_pkg::*;
#(
  parameter int unsigned CNT_W = POS_W,
  parameter int unsigned WID_W = PW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             shadow_en,
  input  logic             load_sel,
  input  logic [WID_W-1:0] pulse_width,
  input  logic             sync_low,
  input  logic [CNT_W-1:0] count,
  input  logic             match_clr,
  input  logic             ready_clr,
  output logic             match_flag,
  output logic             ready_flag,
  output logic             sync_out
);
  logic [CNT_W-1:0] active;
  logic             match_evt;
  logic             zero_evt;
  logic             load_now;
  logic             xfer;
  logic             match_q;
  logic             ready_q;
  load_sel_e        mode;

  assign mode     = load_sel_e'(load_sel);
  assign load_now = (mode == LOAD_AT_ZERO) ? zero_evt : match_evt;

  pcu_event_det #(.W(CNT_W)) u_det (
    .clk(clk), .rst(rst), .count(count), .active(active),
    .match_evt(match_evt), .zero_evt(zero_evt)
  );

  pcu_cmp_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .shadow_en(shadow_en), .load_now(load_now),
    .active_o(active), .xfer_o(xfer)
  );

  pcu_pulse_gen #(.PW(WID_W)) u_pulse (
    .clk(clk), .rst(rst), .trig_i(match_evt), .width_i(pulse_width),
    .low_i(sync_low), .sync_o(sync_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      if (match_evt)      match_q <= 1'b1;
      else if (match_clr) match_q <= 1'b0;
      if (xfer)           ready_q <= 1'b1;
      else if (ready_clr) ready_q <= 1'b0;
    end
  end

  assign match_flag = match_q;
  assign ready_flag = ready_q;

  // R6
  match_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(match_q) |-> $past(match_evt));

  // R5
  ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(xfer));

  // R7
  match_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (match_q && !match_clr) |=> match_q);

  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !ready_clr) |=> ready_q);
endmodule

// File: tb/pos_compare_unit_test.sv
module pos_compare_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        shadow_en = 1'b0;
  logic        load_sel = 1'b0;
  logic [7:0]  pulse_width = '0;
  logic        sync_low = 1'b0;
  logic [31:0] count = '0;
  logic        match_clr = 1'b0;
  logic        ready_clr = 1'b0;
  logic        match_flag, ready_flag, sync_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pos_compare_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .shadow_en(shadow_en), .load_sel(load_sel), .pulse_width(pulse_width),
    .sync_low(sync_low), .count(count), .match_clr(match_clr),
    .ready_clr(ready_clr), .match_flag(match_flag), .ready_flag(ready_flag),
    .sync_out(sync_out)
  );

  // {count, match_clr, expected match_flag}; active compare value is 100
  localparam logic [33:0] VEC [8] = '{
    {32'd99,  1'b0, 1'b0},
    {32'd100, 1'b0, 1'b1},
    {32'd100, 1'b1, 1'b0},
    {32'd101, 1'b0, 1'b0},
    {32'd100, 1'b1, 1'b1},
    {32'd100, 1'b1, 1'b0},
    {32'd5,   1'b0, 1'b0},
    {32'd100, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] c, input logic mc, input logic rc);
    count = c; match_clr = mc; ready_clr = rc;
    @(negedge clk);
    match_clr = 1'b0; ready_clr = 1'b0;
  endtask

  task automatic write_cmp(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 match_flag", match_flag, 0);
    check("R11 ready_flag", ready_flag, 0);
    check("R11 sync_out", sync_out, 0);

    // R1 direct write, then table walk (R6, R7)
    write_cmp(32'd100);
    foreach (VEC[i]) begin
      apply(VEC[i][33:2], VEC[i][1], 1'b0);
      check($sformatf("R6/R7/R1 row %0d", i), match_flag, VEC[i][0]);
    end
    idle(8);
    apply(32'd100, 1'b1, 1'b0);

    // R8, R9 pulse length with retrigger
    pulse_width = 8'd2;
    apply(32'd50, 1'b0, 1'b0);
    idle(2);
    check("R8 idle low", sync_out, 0);
    apply(32'd100, 1'b0, 1'b0);
    n = 0;
    while (sync_out == 1'b1 && n < 2000) begin
      n++;
      if (n == 3) count = 32'd7;
      if (n == 5) count = 32'd100;
      @(negedge clk);
    end
    check("R8/R9 pulse cycles", n, 12);
    idle(3);
    check("R9 stays low", sync_out, 0);

    // R10 polarity
    pulse_width = 8'd0;
    sync_low = 1'b1;
    apply(32'd50, 1'b0, 1'b0);
    idle(1);
    check("R10 idle high", sync_out, 1);
    apply(32'd100, 1'b0, 1'b0);
    n = 0;
    while (sync_out == 1'b0 && n < 2000) begin
      n++;
      @(negedge clk);
    end
    check("R10 low cycles", n, 4);
    sync_low = 1'b0;
    idle(2);
    apply(32'd100, 1'b1, 1'b1);

    // R2, R3, R5 shadow with load on match
    shadow_en = 1'b1;
    load_sel = 1'b0;
    write_cmp(32'd200);
    apply(32'd200, 1'b0, 1'b0);
    check("R2 no match on holding value", match_flag, 0);
    check("R5 no ready before load", ready_flag, 0);
    apply(32'd100, 1'b0, 1'b0);
    check("R3 old value matched", match_flag, 1);
    check("R5 ready after load", ready_flag, 1);
    apply(32'd100, 1'b1, 1'b1);
    check("R7 ready cleared", ready_flag, 0);
    apply(32'd200, 1'b0, 1'b0);
    check("R3 new value matched", match_flag, 1);
    idle(6);
    apply(32'd200, 1'b1, 1'b1);

    // R4 load at zero
    load_sel = 1'b1;
    write_cmp(32'd300);
    apply(32'd300, 1'b0, 1'b0);
    check("R4 no match before zero", match_flag, 0);
    apply(32'd0, 1'b0, 1'b0);
    check("R4 ready at zero", ready_flag, 1);
    apply(32'd0, 1'b0, 1'b1);
    apply(32'd300, 1'b0, 1'b0);
    check("R4 match on loaded value", match_flag, 1);
    check("R4 no load on match", ready_flag, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule